// File: doc/BRIEF.md
# Radix-4 Booth Carry-Save Multiply-Accumulate Unit

This block multiplies two 32-bit operands sequentially and returns the low 32 bits of the product, or that product plus a third operand when the accumulate mode is selected. Each accepted operation walks through the multiplier operand eight bits at a time. Those eight bits become four radix-4 Booth digits, and each digit selects 0, ±1 or ±2 times the multiplicand. The selected multiples are folded into a redundant pair of words, a partial sum and a partial carry, by rows of 3:2 carry-save adders. Carries do not ripple between cycles. Once every multiplier bit has been used, one carry-propagate addition resolves the pair into the result.

The operand side is a valid/ready stream. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while an operation is in flight. An offer made while `in_ready` is low is not taken, and the source must hold it until `in_ready` returns. The result side has no back-pressure. `out_valid` is a single-cycle strobe, and `out_result` keeps its value until the next result is produced.

Top module: `booth_csa_mac`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `in_ready` is 1 and `out_result` is 0.
- R2: With `in_accum` = 0, `out_result` equals the low 32 bits of `in_mcand` × `in_mplier`. This value is the same whether the operands are read as two's-complement or as unsigned.
- R3: With `in_accum` = 1, `out_result` equals the low 32 bits of `in_mcand` × `in_mplier` + `in_addend`.
- R4: `out_valid` is high for exactly one cycle. It rises on the fifth rising edge after the accepting edge: four accumulation edges followed by one final-add edge.
- R5: `in_ready` is low from the accepting edge until the edge that raises `out_valid`. An offer made during that window is not taken: the result and its timing stay those of the running operation, and no extra `out_valid` follows.
- R6: Between strobes, `out_result` holds the last result.
- R7: Multiplier bit triples (upper, middle, lower) map to Booth digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives −2; 101 and 110 give −1. The bit below bit 0 is taken as 0. A zero digit is never marked negative. Products with the operands 0, 0xFFFFFFFF, 0x80000000, 0xAAAAAAAA and 0x55555555 are exact.
- R8: `in_ready` is high again in the cycle in which `out_valid` is high, so a new operation can be accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit idle; the offer is taken this edge |
| in_mcand | input | 32 | Multiplicand |
| in_mplier | input | 32 | Multiplier, recoded eight bits per cycle |
| in_addend | input | 32 | Value added in accumulate mode |
| in_accum | input | 1 | 1 selects multiply-accumulate |
| out_valid | output | 1 | One-cycle strobe: result ready |
| out_result | output | 32 | Low 32 bits of the result, held until the next one |

## Verification
The properties assume that `in_valid` and the operand pins are never X once reset is released. They also assume that the source treats `in_ready` as the only acceptance condition, so any offer made while `in_ready` is low is simply not taken. The stimulus drives every input on the falling edge and keeps all operands defined at all times. It deliberately raises `in_valid` with unrelated operands in the middle of an operation, to exercise the window in which offers must not be taken. Random operands from a fixed seed, in both modes, are mixed with the corner words whose Booth digits hit every table entry.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FINAL = 2'd2
  } mac_state_t;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

  // triple = {upper, middle, lower}
  function automatic bdigit_t booth_encode(input logic [2:0] triple);
    bdigit_t d;
    d.neg = triple[2] & ~(triple[1] & triple[0]);
    d.one = triple[1] ^ triple[0];
    d.two = (triple == 3'b011) || (triple == 3'b100);
    return d;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mac_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [2:0]       triple,
  input  logic [WIDTH-1:0] mcand,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] pp,
  output logic [WIDTH-1:0] corr,
  output bdigit_t          digit
);

  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] inv;

  always_comb begin
    digit = booth_encode(triple);
    if (digit.two)      base = {mcand[WIDTH-2:0], 1'b0};
    else if (digit.one) base = mcand;
    else                base = '0;
    inv  = digit.neg ? ~base : base;
    pp   = inv << shamt;
    corr = digit.neg ? (WIDTH'(1) << shamt) : '0;
  end

endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] z,
  output logic [WIDTH-1:0] s,
  output logic [WIDTH-1:0] c
);

  logic [WIDTH-1:0] maj;

  always_comb begin
    s   = x ^ y ^ z;
    maj = (x & y) | (x & z) | (y & z);
    c   = {maj[WIDTH-2:0], 1'b0};
  end

endmodule

// File: rtl/cpa_add.sv
module cpa_add #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  assign y = a + b;

endmodule

// File: rtl/booth_csa_mac.sv
module booth_csa_mac
  import booth_mac_pkg::*;
#(
  parameter int WIDTH           = 32,
  parameter int DIGITS_PER_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_mcand,
  input  logic [WIDTH-1:0] in_mplier,
  input  logic [WIDTH-1:0] in_addend,
  input  logic             in_accum,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result
);

  localparam int BITS_PER_CYC = 2 * DIGITS_PER_CYC;
  localparam int NCYC         = WIDTH / BITS_PER_CYC;
  localparam int CW           = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam int SHW          = $clog2(WIDTH);
  localparam int NROWS        = DIGITS_PER_CYC + 1;

  mac_state_t       state_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] mc_q;
  logic [WIDTH-1:0] mp_q;
  logic             prev_q;
  logic [WIDTH-1:0] sum_q;
  logic [WIDTH-1:0] car_q;
  logic [WIDTH-1:0] res_q;
  logic             vld_q;

  logic [SHW-1:0]   base_sh;
  logic [WIDTH-1:0] pp_w   [DIGITS_PER_CYC];
  logic [WIDTH-1:0] corr_w [DIGITS_PER_CYC];
  bdigit_t          dig_w  [DIGITS_PER_CYC];
  logic [WIDTH-1:0] corr_all;
  logic [WIDTH-1:0] ops    [NROWS];
  logic [WIDTH-1:0] ch_s   [NROWS+1];
  logic [WIDTH-1:0] ch_c   [NROWS+1];
  logic [WIDTH-1:0] final_sum;

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign base_sh    = SHW'(cnt_q) * SHW'(BITS_PER_CYC);

  // Booth digit selection, one generator per digit of the cycle
  for (genvar k = 0; k < DIGITS_PER_CYC; k++) begin : g_dig
    logic [2:0] trip;
    if (k == 0) begin : g_low
      assign trip = {mp_q[1], mp_q[0], prev_q};
    end else begin : g_hi
      assign trip = {mp_q[2*k+1], mp_q[2*k], mp_q[2*k-1]};
    end

    booth_pp_gen #(.WIDTH(WIDTH), .SHW(SHW)) i_pp (
      .triple (trip),
      .mcand  (mc_q),
      .shamt  (base_sh + SHW'(2*k)),
      .pp     (pp_w[k]),
      .corr   (corr_w[k]),
      .digit  (dig_w[k])
    );

    assign ops[k] = pp_w[k];

    // zero digit never negative, never both one and two
    AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACCUM) |->
        ($onehot0({dig_w[k].one, dig_w[k].two}) &&
         (!dig_w[k].neg || dig_w[k].one || dig_w[k].two))); // R7
  end

  always_comb begin
    corr_all = '0;
    for (int k = 0; k < DIGITS_PER_CYC; k++) corr_all = corr_all | corr_w[k];
  end
  assign ops[DIGITS_PER_CYC] = corr_all;

  // linear carry-save chain: each row folds one operand into the pair
  assign ch_s[0] = sum_q;
  assign ch_c[0] = car_q;
  for (genvar j = 0; j < NROWS; j++) begin : g_row
    csa_row #(.WIDTH(WIDTH)) i_csa (
      .x (ch_s[j]),
      .y (ch_c[j]),
      .z (ops[j]),
      .s (ch_s[j+1]),
      .c (ch_c[j+1])
    );
  end

  cpa_add #(.WIDTH(WIDTH)) i_cpa (
    .a (sum_q),
    .b (car_q),
    .y (final_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mc_q    <= '0;
      mp_q    <= '0;
      prev_q  <= 1'b0;
      sum_q   <= '0;
      car_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            mc_q    <= in_mcand;
            mp_q    <= in_mplier;
            prev_q  <= 1'b0;
            sum_q   <= in_accum ? in_addend : '0;
            car_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_ACCUM;
          end
        end
        ST_ACCUM: begin
          sum_q  <= ch_s[NROWS];
          car_q  <= ch_c[NROWS];
          prev_q <= mp_q[BITS_PER_CYC-1];
          mp_q   <= mp_q >> BITS_PER_CYC;
          cnt_q  <= cnt_q + CW'(1);
          if (cnt_q == CW'(NCYC-1)) state_q <= ST_FINAL;
        end
        ST_FINAL: begin
          res_q   <= final_sum;
          vld_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result)); // R6

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R8

endmodule

// File: tb/test_booth_csa_mac.sv
module test_booth_csa_mac;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_mcand;
  logic [31:0] in_mplier;
  logic [31:0] in_addend;
  logic        in_accum;
  logic        out_valid;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  booth_csa_mac i_booth_csa_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_mcand   (in_mcand),
    .in_mplier  (in_mplier),
    .in_addend  (in_addend),
    .in_accum   (in_accum),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c, input logic acc);
    logic [63:0] p;
    p = a * b;
    return p[31:0] + (acc ? c : 32'd0);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic acc, input bit poke, input string req);
    logic [31:0] exp;
    exp = ref_result(a, b, c, acc);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_mcand  = a;
    in_mplier = b;
    in_addend = c;
    in_accum  = acc;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk);
      if (e < 5) begin
        check(out_valid == 1'b0, "R4 early strobe", 32'(out_valid), 32'd0);
        check(in_ready == 1'b0, "R5 ready while busy", 32'(in_ready), 32'd0);
      end else begin
        check(out_valid == 1'b1, "R4 strobe on fifth edge", 32'(out_valid), 32'd1);
        check(out_result == exp, req, out_result, exp);
        check(in_ready == 1'b1, "R8 ready with strobe", 32'(in_ready), 32'd1);
      end
      if (poke && e == 2) begin
        in_valid  = 1'b1;
        in_mcand  = 32'h1234_5678;
        in_mplier = 32'h0BAD_F00D;
        in_addend = 32'h5555_0000;
        in_accum  = 1'b1;
      end
      if (poke && e == 3) in_valid = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] corner [5];
    logic [31:0] held;
    corner[0] = 32'h0000_0000;
    corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000;
    corner[3] = 32'hAAAA_AAAA;
    corner[4] = 32'h5555_5555;
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_mcand  = '0;
    in_mplier = '0;
    in_addend = '0;
    in_accum  = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
    check(out_result == 32'd0, "R1 out_result in reset", out_result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

    run_op(32'd7, 32'd6, 32'd0, 1'b0, 1'b0, "R2 small product");
    run_op(32'd7, 32'hFFFF_FFFA, 32'd0, 1'b0, 1'b0, "R2 signed product");
    run_op(32'd7, 32'd6, 32'd100, 1'b1, 1'b0, "R3 accumulate");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R3 accumulate wrap");

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        run_op(corner[i], corner[j], 32'd0, 1'b0, 1'b0, "R7 corner operands");

    // offer during busy window is not taken
    run_op(32'h0001_0003, 32'h0000_0101, 32'd9, 1'b1, 1'b1, "R5 busy offer ignored");
    held = out_result;
    repeat (6) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5 no extra strobe", 32'(out_valid), 32'd0);
      check(out_result == held, "R6 result held", out_result, held);
    end

    for (int n = 0; n < 60; n++) begin
      logic [31:0] a, b, c;
      logic acc;
      a   = $urandom;
      b   = $urandom;
      c   = $urandom;
      acc = 1'($urandom);
      run_op(a, b, c, acc, 1'($urandom % 4 == 0), acc ? "R3 random" : "R2 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule